// File: doc/BRIEF.md
# West-First Adaptive Output Port Selector

This block picks the output port for one packet header at a time in a router of a two-dimensional mesh. It compares the packet's destination coordinates with the router's own coordinates and applies a turn-restricted, partially adaptive rule. If the packet still has to travel toward smaller X, the west link is its only choice. Once no westward distance remains, the packet may take any link that shortens a nonzero offset (east, north or south). Per-link busy and fault flags steer the choice toward a link that is both idle and healthy. Because no route ever turns into the west direction, the channel dependence graph stays acyclic. The scheme is therefore free of deadlock without extra virtual channels.

The router presents a request together with the coordinates and the link flags. One clock later the block shows a registered decision. The decision is either a one-hot port with a valid flag, or a wait (no valid, no error), or an unroutable indication. Virtual channel allocation, switching and buffering belong to other blocks.

Top module: `wf_port_select`

## Requirements
- R1: While reset is high, and on the first clock after it, `port_o`, `sel_valid_o` and `unroutable_o` are all zero.
- R2: A cycle with `req_i` low yields zero on all three outputs one clock later, whatever the coordinates and flags.
- R3: Each decision appears on the outputs exactly one clock after the request is sampled and holds for one cycle only.
- R4: When destination and local coordinates are equal on both axes, the port is local (`port_o` = 5'b00001), with valid high, regardless of every busy and fault flag.
- R5: When the destination X is smaller than the local X, the only port ever chosen is west (`port_o` = 5'b00100), whatever the Y offset or the state of the other links.
- R6: When the destination X is smaller than the local X and the west link is busy but not faulty, valid and unroutable both stay low (the packet waits).
- R7: When the destination X is smaller than the local X and the west link is faulty, `unroutable_o` is high and valid is low.
- R8: With no westward distance left, the candidates are exactly: east if the destination X is larger, north if the destination Y is larger, south if the destination Y is smaller. A link that is not a candidate is never chosen, even if it is idle.
- R9: A chosen link always had both its busy and fault flags clear in the sampled cycle.
- R10: Among candidates with both flags clear, east beats north and north beats south (port codes east 5'b00010, north 5'b01000, south 5'b10000).
- R11: If at least one candidate is healthy but every healthy candidate is busy, valid and unroutable both stay low.
- R12: If every candidate is faulty, `unroutable_o` is high and valid is low.
- R13: Valid high implies exactly one bit set in `port_o`. Valid low implies `port_o` is zero. Unroutable and valid are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | A header is present this cycle |
| dst_x_i | input | COORD_W | Destination X coordinate (unsigned, grows eastward) |
| dst_y_i | input | COORD_W | Destination Y coordinate (unsigned, grows northward) |
| cur_x_i | input | COORD_W | This router's X coordinate |
| cur_y_i | input | COORD_W | This router's Y coordinate |
| busy_i | input | 4 | Link busy flags: bit0 east, bit1 west, bit2 north, bit3 south |
| fault_i | input | 4 | Link fault flags, same bit order as busy_i |
| port_o | output | 5 | One-hot port: bit0 local, bit1 east, bit2 west, bit3 north, bit4 south |
| sel_valid_o | output | 1 | A port was chosen |
| unroutable_o | output | 1 | All candidate links are faulty |

## Verification
The bench builds the selector with COORD_W = 4, so each axis spans 0 to 15. At this width the coordinate extremes are cheap to reach. Full-span offsets such as (0,0) to (15,15) and (15,0) to (0,15) test the magnitude comparators exactly where a narrow signed difference would wrap. Most scenarios place the router at (5,5) so that every sign combination of the two offsets can be produced alongside arbitrary busy and fault patterns.

// File: rtl/wf_pkg.sv
package wf_pkg;
  localparam int unsigned LINK_N = 4;
  localparam int unsigned PORT_N = LINK_N + 1;

  // link indices (busy/fault vectors); port index = link index + 1
  localparam int unsigned LNK_E = 0;
  localparam int unsigned LNK_W = 1;
  localparam int unsigned LNK_N = 2;
  localparam int unsigned LNK_S = 3;

  localparam int unsigned PRT_LOCAL = 0;

  typedef logic [LINK_N-1:0] link_vec_t;
  typedef logic [PORT_N-1:0] port_vec_t;

  typedef struct packed {
    logic ahead;   // destination coordinate larger
    logic behind;  // destination coordinate smaller
  } axis_rel_t;
endpackage

// File: rtl/wf_axis_cmp.sv
module wf_axis_cmp #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0]      dst_i,
  input  logic [W-1:0]      cur_i,
  output wf_pkg::axis_rel_t rel_o
);
  // direct magnitude compare, no subtraction and no sign bit
  always_comb begin
    rel_o.ahead  = dst_i > cur_i;
    rel_o.behind = dst_i < cur_i;
  end
endmodule

// File: rtl/wf_cand_mask.sv
module wf_cand_mask
  import wf_pkg::*;
(
  input  axis_rel_t x_rel_i,
  input  axis_rel_t y_rel_i,
  input  link_vec_t busy_i,
  input  link_vec_t fault_i,
  output logic      at_dest_o,
  output link_vec_t cand_o,
  output link_vec_t usable_o,
  output link_vec_t free_o
);
  always_comb begin
    at_dest_o = !(x_rel_i.ahead | x_rel_i.behind | y_rel_i.ahead | y_rel_i.behind);
    cand_o = '0;
    if (x_rel_i.behind) begin
      // westward hops come first: nothing else is eligible
      cand_o[LNK_W] = 1'b1;
    end else begin
      cand_o[LNK_E] = x_rel_i.ahead;
      cand_o[LNK_N] = y_rel_i.ahead;
      cand_o[LNK_S] = y_rel_i.behind;
    end
    usable_o = cand_o & ~fault_i;
    free_o   = usable_o & ~busy_i;
  end
endmodule

// File: rtl/wf_prio_pick.sv
module wf_prio_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  // lowest index wins; prefix chain built per bit
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign gnt_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req_i[i];
  end
endmodule

// File: rtl/wf_port_select.sv
module wf_port_select
  import wf_pkg::*;
#(
  parameter int unsigned COORD_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_i,
  input  logic [COORD_W-1:0] dst_x_i,
  input  logic [COORD_W-1:0] dst_y_i,
  input  logic [COORD_W-1:0] cur_x_i,
  input  logic [COORD_W-1:0] cur_y_i,
  input  logic [3:0]         busy_i,
  input  logic [3:0]         fault_i,
  output logic [4:0]         port_o,
  output logic               sel_valid_o,
  output logic               unroutable_o
);
  axis_rel_t x_rel, y_rel;
  logic      at_dest;
  link_vec_t cand, usable, free, pick;
  port_vec_t port_d;
  logic      valid_d, unr_d;

  wf_axis_cmp #(.W(COORD_W)) u_cmp_x (.dst_i(dst_x_i), .cur_i(cur_x_i), .rel_o(x_rel));
  wf_axis_cmp #(.W(COORD_W)) u_cmp_y (.dst_i(dst_y_i), .cur_i(cur_y_i), .rel_o(y_rel));

  wf_cand_mask u_mask (
    .x_rel_i  (x_rel),
    .y_rel_i  (y_rel),
    .busy_i   (busy_i),
    .fault_i  (fault_i),
    .at_dest_o(at_dest),
    .cand_o   (cand),
    .usable_o (usable),
    .free_o   (free)
  );

  // link order E,W,N,S: W is never in free together with others,
  // so lowest-index-first yields east > north > south
  wf_prio_pick #(.N(LINK_N)) u_pick (.req_i(free), .gnt_o(pick));

  always_comb begin
    port_d  = '0;
    valid_d = 1'b0;
    unr_d   = 1'b0;
    if (req_i) begin
      if (at_dest) begin
        port_d[PRT_LOCAL] = 1'b1;
        valid_d           = 1'b1;
      end else if (usable == '0) begin
        unr_d = 1'b1;
      end else if (free != '0) begin
        port_d  = {pick, 1'b0};
        valid_d = 1'b1;
      end
      // otherwise: healthy candidates all busy -> wait
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      port_o       <= '0;
      sel_valid_o  <= 1'b0;
      unroutable_o <= 1'b0;
    end else begin
      port_o       <= port_d;
      sel_valid_o  <= valid_d;
      unroutable_o <= unr_d;
    end
  end

  // ---------------- assertions ----------------
  assert_onehot_R13: assert property (@(posedge clk) disable iff (rst)
    sel_valid_o |-> $countones(port_o) == 1);

  assert_idle_port_R13: assert property (@(posedge clk) disable iff (rst)
    !sel_valid_o |-> port_o == '0);

  assert_unr_excl_R12: assert property (@(posedge clk) disable iff (rst)
    unroutable_o |-> !sel_valid_o);

  assert_west_first_R5: assert property (@(posedge clk) disable iff (rst)
    (sel_valid_o && (port_o[1] || port_o[3] || port_o[4])) |->
      !$past(dst_x_i < cur_x_i));

  assert_link_ok_R9: assert property (@(posedge clk) disable iff (rst)
    sel_valid_o |-> ((($past(busy_i) | $past(fault_i)) & port_o[4:1]) == 4'b0));

  assert_local_R4: assert property (@(posedge clk) disable iff (rst)
    (sel_valid_o && port_o[0]) |->
      $past(dst_x_i == cur_x_i && dst_y_i == cur_y_i));

  assert_no_req_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(req_i) |-> (!sel_valid_o && !unroutable_o));
endmodule

// File: tb/wf_port_select_tb.sv
`timescale 1ns/1ps
module wf_port_select_tb_top;
  localparam int unsigned CW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          req;
  logic [CW-1:0] dx, dy, cx, cy;
  logic [3:0]    busy, fault;
  logic [4:0]    port;
  logic          vld, unr;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [4:0] P_L = 5'b00001, P_E = 5'b00010, P_W = 5'b00100,
                         P_N = 5'b01000, P_S = 5'b10000, P_0 = 5'b00000;
  // link flag bits: 0 E, 1 W, 2 N, 3 S
  localparam logic [3:0] F_E = 4'b0001, F_W = 4'b0010, F_N = 4'b0100, F_S = 4'b1000;

  always #2.5 clk = ~clk;

  wf_port_select #(.COORD_W(CW)) dut_i (
    .clk(clk), .rst(rst), .req_i(req),
    .dst_x_i(dx), .dst_y_i(dy), .cur_x_i(cx), .cur_y_i(cy),
    .busy_i(busy), .fault_i(fault),
    .port_o(port), .sel_valid_o(vld), .unroutable_o(unr)
  );

  task automatic check(input string tag, input logic [4:0] ep,
                       input logic ev, input logic eu);
    n_chk++;
    if (port !== ep || vld !== ev || unr !== eu) begin
      n_fail++;
      $display("FAIL %s: got port=%b valid=%b unr=%b, expected port=%b valid=%b unr=%b",
               tag, port, vld, unr, ep, ev, eu);
    end
  endtask

  // drive at negedge, result registered at next posedge, sample at next negedge
  task automatic step(input logic r, input int tx, input int ty, input int ux,
                      input int uy, input logic [3:0] b, input logic [3:0] f);
    req = r; dx = tx[CW-1:0]; dy = ty[CW-1:0]; cx = ux[CW-1:0]; cy = uy[CW-1:0];
    busy = b; fault = f;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(1'b1, 9, 9, 5, 5, 4'b0, 4'b0);
    check("R1 in reset", P_0, 1'b0, 1'b0);
    step(1'b1, 9, 9, 5, 5, 4'b0, 4'b0);
    check("R1 held reset", P_0, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_no_req();
    step(1'b0, 9, 9, 5, 5, 4'b0, 4'b0);
    check("R2 idle", P_0, 1'b0, 1'b0);
    step(1'b0, 2, 2, 5, 5, 4'b0, 4'hF);
    check("R2 idle faults", P_0, 1'b0, 1'b0);
  endtask

  task automatic t_latency();
    step(1'b1, 9, 5, 5, 5, 4'b0, 4'b0);
    check("R3 one clock", P_E, 1'b1, 1'b0);
    step(1'b0, 9, 5, 5, 5, 4'b0, 4'b0);
    check("R3 single cycle", P_0, 1'b0, 1'b0);
  endtask

  task automatic t_local();
    step(1'b1, 5, 5, 5, 5, 4'hF, 4'hF);
    check("R4 local flags ignored", P_L, 1'b1, 1'b0);
    step(1'b1, 0, 15, 0, 15, 4'b0, 4'b0);
    check("R4 local edge", P_L, 1'b1, 1'b0);
  endtask

  task automatic t_west();
    step(1'b1, 2, 9, 5, 5, 4'b0, 4'b0);
    check("R5 west north offset", P_W, 1'b1, 1'b0);
    step(1'b1, 2, 1, 5, 5, F_E | F_N | F_S, 4'b0);
    check("R5 west others busy", P_W, 1'b1, 1'b0);
    step(1'b1, 2, 9, 5, 5, F_W, 4'b0);
    check("R6 west busy waits", P_0, 1'b0, 1'b0);
    step(1'b1, 2, 5, 5, 5, F_W, F_E);
    check("R6 no detour", P_0, 1'b0, 1'b0);
    step(1'b1, 2, 9, 5, 5, 4'b0, F_W);
    check("R7 west faulty", P_0, 1'b0, 1'b1);
  endtask

  task automatic t_candidates();
    step(1'b1, 9, 5, 5, 5, 4'b0, 4'b0);
    check("R8 east only", P_E, 1'b1, 1'b0);
    step(1'b1, 5, 9, 5, 5, 4'b0, 4'b0);
    check("R8 north only", P_N, 1'b1, 1'b0);
    step(1'b1, 5, 1, 5, 5, 4'b0, 4'b0);
    check("R8 south only", P_S, 1'b1, 1'b0);
    step(1'b1, 5, 9, 5, 5, F_N, 4'b0);
    check("R8 idle east not candidate", P_0, 1'b0, 1'b0);
  endtask

  task automatic t_adaptive();
    step(1'b1, 9, 9, 5, 5, 4'b0, 4'b0);
    check("R10 east over north", P_E, 1'b1, 1'b0);
    step(1'b1, 9, 1, 5, 5, 4'b0, 4'b0);
    check("R10 east over south", P_E, 1'b1, 1'b0);
    step(1'b1, 9, 9, 5, 5, F_E, 4'b0);
    check("R9 east busy to north", P_N, 1'b1, 1'b0);
    step(1'b1, 9, 1, 5, 5, 4'b0, F_E);
    check("R9 east faulty to south", P_S, 1'b1, 1'b0);
    step(1'b1, 9, 9, 5, 5, F_E | F_N, 4'b0);
    check("R11 all busy waits", P_0, 1'b0, 1'b0);
    step(1'b1, 9, 9, 5, 5, F_E, F_N);
    check("R11 busy plus faulty waits", P_0, 1'b0, 1'b0);
    step(1'b1, 9, 9, 5, 5, 4'b0, F_E | F_N);
    check("R12 all faulty", P_0, 1'b0, 1'b1);
    step(1'b1, 5, 1, 5, 5, 4'b0, F_S);
    check("R12 single faulty", P_0, 1'b0, 1'b1);
  endtask

  task automatic t_corners();
    step(1'b1, 15, 15, 0, 0, 4'b0, 4'b0);
    check("R13 full span east", P_E, 1'b1, 1'b0);
    step(1'b1, 0, 0, 15, 15, 4'b0, 4'b0);
    check("R5 full span west", P_W, 1'b1, 1'b0);
    step(1'b1, 0, 15, 15, 0, F_E, 4'b0);
    check("R5 wrap corner", P_W, 1'b1, 1'b0);
    step(1'b1, 15, 0, 0, 15, F_E, 4'b0);
    check("R10 wrap south", P_S, 1'b1, 1'b0);
  endtask

  initial begin
    req = 1'b0; dx = '0; dy = '0; cx = '0; cy = '0; busy = '0; fault = '0;
    rst = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_req();
    t_latency();
    t_local();
    t_west();
    t_candidates();
    t_adaptive();
    t_corners();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got no completion, expected completion within 20000 cycles");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule